// File: doc/BRIEF.md
# Calibration Pass-Window Centre Finder

This block picks a safe operating point from the results of an interface timing sweep. The sweep tries every pairing of a drive-phase setting with a sample-phase setting and records one pass/fail bit for each pairing. The result is a 7-row by 8-column map. Rows index the drive phase and columns index the sample phase. The block looks for the largest axis-aligned rectangle of passing cells in this map. It reports a cell near the middle of that rectangle, which is the setting farthest from the failing edges.

A run begins with a one-cycle start pulse. The surrounding logic raises it each time the interface clock frequency or the bus width changes, after it has presented the new map on the pass vector. The block captures the map and counts its passing cells. It settles the two trivial maps (no cell passing, every cell passing) straight away. For any other map it tests one candidate rectangle placement per clock cycle. It stops at the first fit, raises done for one cycle, and leaves the chosen row, column and fail flag on its outputs until the next run completes.

Top module: `calib_window_centre`

## Requirements
- R1: Cell (row r, column c) of the map is bit r*8+c of `passVec`, and a 1 means the setting passed. The reported row and column use the same indexing.
- R2: If no bit of `passVec` is set when start is sampled, the run ends with `failOut`=1. Row and column keep their previous values, and done rises in the cycle right after the clock edge that sampled start.
- R3: If all 56 bits are set when start is sampled, the run ends with row 3, column 3 and `failOut`=0, with done in the cycle right after the sampling edge and no search.
- R4: Rectangle sizes are tried in strictly decreasing area. Among sizes of equal area, the taller one is tried first.
- R5: For one size, placements are tried with the start column as the slow index and the start row as the fast index, both counting up from 0. The first placement whose cells all pass is accepted.
- R6: For an accepted rectangle of height h and width w placed at (r0, c0), each dimension above 1 is first reduced by one. The reported row is r0 plus half the reduced height and the column is c0 plus half the reduced width, both rounded down, with `failOut`=0.
- R7: A searched run tests exactly one placement per cycle. If the accepted placement is the P-th one tried, done rises in the cycle after the P-th rising edge that follows the sampling edge.
- R8: Done is high for exactly one cycle per run.
- R9: A start pulse that arrives while a search is in progress is ignored. The running search keeps its captured map, its result and its timing.
- R10: Row, column and fail hold their values in every cycle in which done is low.
- R11: After reset, done, fail, row and column are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | One-cycle request to start a run on the present map |
| passVec | input | 56 | Pass/fail map, cell (r,c) at bit r*8+c |
| doneOut | output | 1 | One-cycle pulse when a run finishes |
| failOut | output | 1 | 1 when the last finished run found no passing cell |
| rowOut | output | 3 | Chosen drive-phase row |
| colOut | output | 3 | Chosen sample-phase column |

## Verification
The result of a trivial map is due in the first cycle after the edge that samples start. The result of a searched map is due P edges later, where P is the 1-based position of the accepted placement in the search order. The bench's reference model reproduces that order and therefore predicts P for each map. The bench drives and samples on falling edges and counts edges from the start sample until it sees done. It checks that count against P and the result against the model. It then checks that done drops on the next cycle and that the outputs stay put for the idle cycles after it.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } pwinState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;       // capture map, restart at largest size
    logic advPlace;   // move to next placement of current size
    logic advCand;    // move to next smaller candidate size
    logic wrCentre;   // write centre of current placement
    logic wrFixed;    // write the fixed all-pass centre
    logic wrFail;     // flag failure, keep row/column
    logic searching;  // FSM is in the search state
  } pwinStrobe_t;

endpackage

// File: rtl/pwin_popcount.sv
module pwin_popcount #(
  parameter int W = 56
) (
  input  logic [W-1:0]           vecIn,
  output logic [$clog2(W+1)-1:0] countOut
);
  localparam int CNT_W = $clog2(W + 1);

  always_comb begin
    countOut = '0;
    for (int i = 0; i < W; i++) begin
      countOut = countOut + CNT_W'(vecIn[i]);
    end
  end

endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath
  import pwin_pkg::*;
#(
  parameter int ROWS = 7,
  parameter int COLS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ROWS*COLS-1:0]      passVec,
  input  pwinStrobe_t               strb,
  output logic                      noneIn,
  output logic                      allIn,
  output logic                      fit,
  output logic                      lastPlace,
  output logic                      nextValid,
  output logic [$clog2(ROWS)-1:0]   rowOut,
  output logic [$clog2(COLS)-1:0]   colOut,
  output logic                      failOut
);
  localparam int NCELL = ROWS * COLS;
  localparam int CNT_W = $clog2(NCELL + 1);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int HW    = $clog2(ROWS + 1);
  localparam int WW    = $clog2(COLS + 1);
  localparam int FIX_ROW = (ROWS - 1) / 2;
  localparam int FIX_COL = (COLS - 1) / 2;

  logic [NCELL-1:0] mapQ;
  logic [HW-1:0]    candH;
  logic [WW-1:0]    candW;
  logic [RW-1:0]    startRow;
  logic [CW-1:0]    startCol;
  logic [RW-1:0]    rowQ;
  logic [CW-1:0]    colQ;
  logic             failQ;

  // Pass count of the incoming map
  logic [CNT_W-1:0] passCount;

  pwin_popcount #(.W(NCELL)) u_popcount (
    .vecIn    (passVec),
    .countOut (passCount)
  );

  assign noneIn = (passCount == '0);
  assign allIn  = (passCount == CNT_W'(NCELL));

  // Rectangle mask against captured map
  logic [ROWS-1:0]  inRow;
  logic [COLS-1:0]  inCol;
  logic [NCELL-1:0] cellOk;

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    assign inRow[gr] = (gr >= int'(startRow)) && (gr < int'(startRow) + int'(candH));
  end

  for (genvar gc = 0; gc < COLS; gc++) begin : g_col
    assign inCol[gc] = (gc >= int'(startCol)) && (gc < int'(startCol) + int'(candW));
  end

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_cell_r
    for (genvar gc = 0; gc < COLS; gc++) begin : g_cell_c
      assign cellOk[gr*COLS+gc] = mapQ[gr*COLS+gc] | ~(inRow[gr] & inCol[gc]);
    end
  end

  assign fit = &cellOk;

  // Placement stepping
  logic rowRoom;
  logic colRoom;

  assign rowRoom   = int'(startRow) < (ROWS - int'(candH));
  assign colRoom   = int'(startCol) < (COLS - int'(candW));
  assign lastPlace = !rowRoom && !colRoom;

  // Next candidate size: order key = area*(ROWS+1)+height, largest key below current
  logic [HW-1:0] nextH;
  logic [WW-1:0] nextW;

  always_comb begin
    int curKey;
    int bestKey;
    int key;
    curKey  = int'(candH) * int'(candW) * (ROWS + 1) + int'(candH);
    bestKey = -1;
    nextH   = '0;
    nextW   = '0;
    for (int hh = 1; hh <= ROWS; hh++) begin
      for (int ww = 1; ww <= COLS; ww++) begin
        key = hh * ww * (ROWS + 1) + hh;
        if (key < curKey && key > bestKey) begin
          bestKey = key;
          nextH   = HW'(hh);
          nextW   = WW'(ww);
        end
      end
    end
    nextValid = (bestKey >= 0);
  end

  // Centre of current placement
  logic [HW-1:0] hRed;
  logic [WW-1:0] wRed;
  logic [RW-1:0] centreRow;
  logic [CW-1:0] centreCol;

  assign hRed      = (candH > HW'(1)) ? candH - HW'(1) : candH;
  assign wRed      = (candW > WW'(1)) ? candW - WW'(1) : candW;
  assign centreRow = RW'(int'(startRow) + int'(hRed) / 2);
  assign centreCol = CW'(int'(startCol) + int'(wRed) / 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapQ     <= '0;
      candH    <= HW'(ROWS);
      candW    <= WW'(COLS);
      startRow <= '0;
      startCol <= '0;
      rowQ     <= '0;
      colQ     <= '0;
      failQ    <= 1'b0;
    end else begin
      if (strb.load) begin
        mapQ     <= passVec;
        candH    <= HW'(ROWS);
        candW    <= WW'(COLS);
        startRow <= '0;
        startCol <= '0;
      end
      if (strb.advPlace) begin
        if (rowRoom) begin
          startRow <= startRow + RW'(1);
        end else begin
          startRow <= '0;
          startCol <= startCol + CW'(1);
        end
      end
      if (strb.advCand) begin
        candH    <= nextH;
        candW    <= nextW;
        startRow <= '0;
        startCol <= '0;
      end
      if (strb.wrCentre) begin
        rowQ  <= centreRow;
        colQ  <= centreCol;
        failQ <= 1'b0;
      end
      if (strb.wrFixed) begin
        rowQ  <= RW'(FIX_ROW);
        colQ  <= CW'(FIX_COL);
        failQ <= 1'b0;
      end
      if (strb.wrFail) begin
        failQ <= 1'b1;
      end
    end
  end

  assign rowOut  = rowQ;
  assign colOut  = colQ;
  assign failOut = failQ;

  // R9: captured map is untouched while a search runs
  assert_map_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.searching |=> $stable(mapQ));

  // R6: a written centre lies inside the map
  assert_centre_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCentre |=> (int'(rowQ) < ROWS) && (int'(colQ) < COLS));

  // R1: a written centre lands on a passing cell of the captured map
  assert_centre_passes_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCentre |=> mapQ[int'(rowQ)*COLS + int'(colQ)]);

endmodule

// File: rtl/pwin_ctrl.sv
module pwin_ctrl
  import pwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        noneIn,
  input  logic        allIn,
  input  logic        fit,
  input  logic        lastPlace,
  input  logic        nextValid,
  output pwinStrobe_t strb,
  output logic        doneOut
);
  pwinState_t stateQ, stateD;
  logic       doneQ, doneD;

  always_comb begin
    strb           = '0;
    stateD         = stateQ;
    doneD          = 1'b0;
    strb.searching = (stateQ == ST_SEARCH);
    case (stateQ)
      ST_IDLE: begin
        if (startIn) begin
          if (noneIn) begin
            strb.wrFail = 1'b1;
            doneD       = 1'b1;
          end else if (allIn) begin
            strb.wrFixed = 1'b1;
            doneD        = 1'b1;
          end else begin
            strb.load = 1'b1;
            stateD    = ST_SEARCH;
          end
        end
      end
      ST_SEARCH: begin
        if (fit) begin
          strb.wrCentre = 1'b1;
          doneD         = 1'b1;
          stateD        = ST_IDLE;
        end else if (!lastPlace) begin
          strb.advPlace = 1'b1;
        end else if (nextValid) begin
          strb.advCand = 1'b1;
        end else begin
          strb.wrFail = 1'b1;
          doneD       = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  assign doneOut = doneQ;

  // R8: done never lasts two cycles unless a fresh start was sampled
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !startIn) |=> !doneQ);

  // R7: every search cycle does exactly one step
  assert_one_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.searching |-> ($countones({strb.advPlace, strb.advCand, strb.wrCentre, strb.wrFail}) == 1));

endmodule

// File: rtl/calib_window_centre.sv
module calib_window_centre
  import pwin_pkg::*;
#(
  parameter int ROWS = 7,
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [ROWS*COLS-1:0]    passVec,
  output logic                    doneOut,
  output logic                    failOut,
  output logic [$clog2(ROWS)-1:0] rowOut,
  output logic [$clog2(COLS)-1:0] colOut
);
  pwinStrobe_t strb;
  logic noneIn, allIn, fit, lastPlace, nextValid;

  pwin_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .noneIn    (noneIn),
    .allIn     (allIn),
    .fit       (fit),
    .lastPlace (lastPlace),
    .nextValid (nextValid),
    .strb      (strb),
    .doneOut   (doneOut)
  );

  pwin_datapath #(.ROWS(ROWS), .COLS(COLS)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .passVec   (passVec),
    .strb      (strb),
    .noneIn    (noneIn),
    .allIn     (allIn),
    .fit       (fit),
    .lastPlace (lastPlace),
    .nextValid (nextValid),
    .rowOut    (rowOut),
    .colOut    (colOut),
    .failOut   (failOut)
  );

  // R10: results move only together with done
  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> ($stable(rowOut) && $stable(colOut) && $stable(failOut)));

endmodule

// File: tb/calib_window_centre_bench.sv
module calib_window_centre_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 7;
  localparam int COLS = 8;
  localparam int NC   = ROWS * COLS;
  localparam int RUN_LIMIT = 3000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [NC-1:0] passVec = '0;
  logic          doneOut, failOut;
  logic [2:0]    rowOut, colOut;

  int checks = 0;
  int failures = 0;
  int expRow = 0;
  int expCol = 0;

  calib_window_centre u_calib_window_centre (
    .clk(clk), .rstN(rstN), .startIn(startIn), .passVec(passVec),
    .doneOut(doneOut), .failOut(failOut), .rowOut(rowOut), .colOut(colOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] rectMask(input int r0, input int c0, input int h, input int w);
    logic [NC-1:0] m = '0;
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++)
        m[r*COLS+c] = 1'b1;
    return m;
  endfunction

  // Reference: order by area down, taller first; column-major placements.
  function automatic void refModel(input logic [NC-1:0] v, inout int eRow, inout int eCol,
                                   output bit eFail, output int eLat);
    int pop, placed, w, hr, wr;
    bit found, ok;
    pop = $countones(v);
    eLat = 0;
    eFail = 1'b1;
    if (pop == 0) return;
    if (pop == NC) begin
      eFail = 1'b0; eRow = (ROWS-1)/2; eCol = (COLS-1)/2;
      return;
    end
    placed = 0; found = 1'b0;
    for (int a = NC; a >= 1 && !found; a--) begin
      for (int h = ROWS; h >= 1 && !found; h--) begin
        if ((a % h) != 0 || (a / h) > COLS) continue;
        w = a / h;
        for (int sc = 0; sc <= COLS - w && !found; sc++) begin
          for (int sr = 0; sr <= ROWS - h && !found; sr++) begin
            placed++;
            ok = 1'b1;
            for (int r = sr; r < sr + h; r++)
              for (int c = sc; c < sc + w; c++)
                if (!v[r*COLS+c]) ok = 1'b0;
            if (ok) begin
              found = 1'b1; eFail = 1'b0;
              hr = (h > 1) ? h - 1 : h;
              wr = (w > 1) ? w - 1 : w;
              eRow = sr + hr / 2;
              eCol = sc + wr / 2;
            end
          end
        end
      end
    end
    eLat = placed;
  endfunction

  task automatic runOne(input logic [NC-1:0] v, input string tag, input bit interfere,
                        input logic [NC-1:0] other);
    int eLat, cyc;
    bit eFail;
    refModel(v, expRow, expCol, eFail, eLat);
    @(negedge clk); startIn = 1'b1; passVec = v;
    @(negedge clk); startIn = 1'b0;
    cyc = 0;
    while (!doneOut && cyc < RUN_LIMIT) begin
      if (interfere && cyc == 2) begin startIn = 1'b1; passVec = other; end
      else startIn = 1'b0;
      @(negedge clk); cyc++;
    end
    startIn = 1'b0;
    if (cyc >= RUN_LIMIT) begin
      chk(1'b0, {tag, " R7 run watchdog"}, cyc, eLat);
      return;
    end
    chk(cyc == eLat, {tag, " R7 latency"}, cyc, eLat);
    chk(failOut == eFail, {tag, " R2 fail flag"}, int'(failOut), int'(eFail));
    chk(int'(rowOut) == expRow, {tag, " R6 row"}, int'(rowOut), expRow);
    chk(int'(colOut) == expCol, {tag, " R6 column"}, int'(colOut), expCol);
    @(negedge clk);
    chk(doneOut == 1'b0, {tag, " R8 done width"}, int'(doneOut), 0);
    @(negedge clk);
    chk(int'(rowOut) == expRow && int'(colOut) == expCol && failOut == eFail,
        {tag, " R10 hold"}, int'(rowOut)*8 + int'(colOut), expRow*8 + expCol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NC-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(doneOut == 0 && failOut == 0, "R11 reset done/fail", int'(doneOut)*2 + int'(failOut), 0);
    chk(rowOut == 0 && colOut == 0, "R11 reset row/col", int'(rowOut)*8 + int'(colOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 before any success: row/col stay at reset values
    runOne('0, "R2 empty map first", 1'b0, '0);
    // R3 full map
    runOne('1, "R3 full map", 1'b0, '0);
    // R2 after success: row/col keep 3/3
    runOne('0, "R2 empty map after full", 1'b0, '0);
    // R1 single cells, worst case and first placement
    runOne(rectMask(6, 7, 1, 1), "R1 single cell bottom right", 1'b0, '0);
    runOne(rectMask(0, 0, 1, 1), "R1 single cell origin", 1'b0, '0);
    runOne(rectMask(2, 5, 1, 1), "R1 single cell middle", 1'b0, '0);
    // All but one cell
    v = '1; v[3*COLS+4] = 1'b0;
    runOne(v, "R6 one hole", 1'b0, '0);
    // R4 tie: 3x2 vs 2x3 of equal area
    runOne(rectMask(4, 0, 2, 3) | rectMask(0, 5, 3, 2), "R4 equal area taller first", 1'b0, '0);
    // R5 scan: two 2x2 blocks, lower-left one is earlier in column order
    runOne(rectMask(4, 1, 2, 2) | rectMask(0, 3, 2, 2), "R5 column major scan", 1'b0, '0);
    // R6 even and odd sizes
    runOne(rectMask(1, 2, 4, 5), "R6 4x5 block", 1'b0, '0);
    runOne(rectMask(0, 0, 7, 1), "R6 full column", 1'b0, '0);
    // R9 start during search is ignored
    runOne(rectMask(6, 7, 1, 1), "R9 restart ignored", 1'b1, '1);

    for (int i = 0; i < 40; i++) begin
      v = '0;
      for (int b = 0; b < NC; b++) v[b] = (($urandom % 10) < ((i % 2 == 0) ? 8 : 5));
      runOne(v, $sformatf("R4 R5 random %0d", i), (i % 5 == 0), ~v);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule